// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. Each pending request is held in a request register, filtered by a mask register, and ranked by a priority resolver against the levels already in service. When a request outranks everything in service, the interrupt output rises. The processor answers with two acknowledge pulses: the first returns a call opcode and moves the winning level from pending to in service; the second returns a vector byte that carries the level number.

Software programs the block through a small register port with one address bit. An initialization sequence of two or three writes selects edge or level triggering, the vector base and automatic end-of-interrupt. After that, mask writes and operation commands control end-of-interrupt handling, priority rotation, special mask mode and which register a read returns. All strobes are active high and sampled on the rising clock edge. The block has no data stream: every register access and every acknowledge pulse is taken in the cycle it is presented, with no back-pressure and no wait state, and read data is combinational in that same cycle.

Top module: `pic_intc`

## Requirements
- R1: After reset the mask register reads 8'hFF, the request and in-service registers are zero, the interrupt output is low, triggering is edge, the vector base is zero and line 0 has the highest priority, line 7 the lowest.
- R2: In edge mode a request bit is set by a rising input and cleared when the input falls before it is acknowledged; in level mode the request bit follows the input level each cycle.
- R3: A write with address 0 and data bit 4 set restarts initialization: bit 3 selects level mode, bit 0 says a mode word follows; it clears the mask and in-service registers, resets priority to line 0 highest, leaves special mask mode, selects the request register for reads and turns automatic end-of-interrupt off. The next address-1 write sets the vector base; if announced, the following address-1 write is the mode word whose bit 1 enables automatic end-of-interrupt. Later address-1 writes go to the mask register.
- R4: Outside special mask mode the interrupt output is high exactly when some unmasked pending request has a strictly higher priority than every in-service level.
- R5: During the first acknowledge pulse the read data is 8'hCD; at that edge, if the interrupt output was high, the winning level's in-service bit is set and its request bit cleared.
- R6: During the second acknowledge pulse the read data is the vector base bits 7..3 joined with the level in bits 2..0; if the interrupt output was low at the first pulse, level 7 is returned and no in-service bit is set.
- R7: Setting a mask bit keeps that line from raising the interrupt output while its request bit is still recorded; clearing it enables the line again.
- R8: A command with address 0, bits 4 and 3 clear, and bits 7..5 equal to 001 clears the highest-priority in-service bit; bits 7..5 equal to 011 clear the in-service bit named by bits 2..0.
- R9: Bits 7..5 equal to 101 clear the highest-priority in-service bit and make that level the lowest priority; 111 clears the named level and makes it lowest; 110 only makes the named level lowest. The level one above the lowest (modulo 8) becomes the highest.
- R10: With automatic end-of-interrupt on, the in-service bit set by the first acknowledge pulse is cleared at the edge of the second pulse.
- R11: A command with address 0, bit 4 clear and bit 3 set enters special mask mode when bits 6 and 5 are both set and leaves it when bit 6 is set and bit 5 clear; in special mask mode the interrupt output is high when any unmasked pending request is not itself in service, whatever its priority.
- R12: With chip select and read high and no acknowledge pulse, address 1 reads the mask register and address 0 reads the request register, or the in-service register after a command of the R11 kind with bit 1 set and bit 0 set (bit 1 set, bit 0 clear selects the request register again). Otherwise read data is zero, and an acknowledge pulse takes precedence.
- R13: A command write and an acknowledge pulse in the same cycle both take effect: the command's end-of-interrupt clear uses the in-service state before the edge and the acknowledge sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select for register access |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, acknowledge bytes during pulses |
| irq_in | input | 8 | Interrupt request lines, bit n is line n |
| inta | input | 1 | Acknowledge pulse, one cycle per pulse |
| intr | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge grant and an end-of-interrupt command can land on the same clock edge, both editing the in-service register. The bench holds one level in service, raises a higher line, then drives the first acknowledge pulse together with a non-specific end-of-interrupt write; the expected result is that the older level is released and the new winner is set, which the following vector byte and an in-service read confirm. A second collision, a line dropping in the same run of cycles in which it would be taken, is judged through the request register read and the interrupt output.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEQ_READY = 2'd0,
    SEQ_BASE  = 2'd1,
    SEQ_MODE  = 2'd2
  } seq_t;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  localparam logic [2:0] OP_NS_EOI     = 3'b001;
  localparam logic [2:0] OP_SP_EOI     = 3'b011;
  localparam logic [2:0] OP_ROT_NS_EOI = 3'b101;
  localparam logic [2:0] OP_ROT_SP_EOI = 3'b111;
  localparam logic [2:0] OP_SET_LOW    = 3'b110;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_in,
  input  logic            level_mode,
  input  logic [NLVL-1:0] take,
  output logic [NLVL-1:0] irr
);
  logic [NLVL-1:0] last_in;

  for (genvar g = 0; g < NLVL; g++) begin : g_line
    logic nxt;
    always_comb begin
      if (level_mode) nxt = irq_in[g];
      else            nxt = (irr[g] | (irq_in[g] & ~last_in[g])) & irq_in[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_in[g] <= 1'b0;
        irr[g]     <= 1'b0;
      end else begin
        last_in[g] <= irq_in[g];
        irr[g]     <= nxt & ~take[g];
      end
    end
  end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] vec,
  input  logic [LW-1:0]   low_lvl,
  output logic            any,
  output logic [LW-1:0]   idx,
  output logic [LW-1:0]   rank
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    rank = '0;
    for (int k = NLVL - 1; k >= 0; k--) begin
      int p;
      p = (int'(low_lvl) + 1 + k) % NLVL;
      if (vec[p]) begin
        any  = 1'b1;
        idx  = LW'(p);
        rank = LW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
  import pic_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int DW   = 8,
  localparam int LW  = $clog2(NLVL),
  localparam int BW  = DW - LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            a0,
  input  logic [DW-1:0]   wdata,
  input  logic            isr_any,
  input  logic [LW-1:0]   isr_hi,
  output logic [NLVL-1:0] imr,
  output logic            level_mode,
  output logic [BW-1:0]   base_hi,
  output logic            auto_eoi,
  output logic            spec_mask,
  output logic            rd_isr,
  output logic [LW-1:0]   low_lvl,
  output logic            init_clr,
  output logic [NLVL-1:0] eoi_clr,
  output logic            seq_ready
);
  seq_t        seq;
  logic        need_mode;
  logic        is_ocw2, is_ocw3;
  logic [2:0]  opcode;
  logic [LW-1:0] sel_lvl;

  assign seq_ready = (seq == SEQ_READY);
  assign init_clr  = we && !a0 && wdata[4];
  assign is_ocw2   = we && !a0 && !wdata[4] && !wdata[3] && seq_ready;
  assign is_ocw3   = we && !a0 && !wdata[4] &&  wdata[3] && seq_ready;
  assign opcode    = wdata[7:5];
  assign sel_lvl   = wdata[LW-1:0];

  always_comb begin
    eoi_clr = '0;
    if (is_ocw2) begin
      unique case (opcode)
        OP_NS_EOI, OP_ROT_NS_EOI: if (isr_any) eoi_clr[isr_hi] = 1'b1;
        OP_SP_EOI, OP_ROT_SP_EOI: eoi_clr[sel_lvl] = 1'b1;
        default: eoi_clr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq        <= SEQ_READY;
      need_mode  <= 1'b0;
      imr        <= '1;
      level_mode <= 1'b0;
      base_hi    <= '0;
      auto_eoi   <= 1'b0;
      spec_mask  <= 1'b0;
      rd_isr     <= 1'b0;
      low_lvl    <= LW'(NLVL - 1);
    end else if (init_clr) begin
      seq        <= SEQ_BASE;
      need_mode  <= wdata[0];
      level_mode <= wdata[3];
      imr        <= '0;
      auto_eoi   <= 1'b0;
      spec_mask  <= 1'b0;
      rd_isr     <= 1'b0;
      low_lvl    <= LW'(NLVL - 1);
    end else if (we && a0) begin
      unique case (seq)
        SEQ_BASE: begin
          base_hi <= wdata[DW-1:LW];
          seq     <= need_mode ? SEQ_MODE : SEQ_READY;
        end
        SEQ_MODE: begin
          auto_eoi <= wdata[1];
          seq      <= SEQ_READY;
        end
        default: imr <= wdata[NLVL-1:0];
      endcase
    end else if (is_ocw2) begin
      unique case (opcode)
        OP_ROT_NS_EOI: if (isr_any) low_lvl <= isr_hi;
        OP_ROT_SP_EOI, OP_SET_LOW: low_lvl <= sel_lvl;
        default: low_lvl <= low_lvl;
      endcase
    end else if (is_ocw3) begin
      if (wdata[6]) spec_mask <= wdata[5];
      if (wdata[1]) rd_isr    <= wdata[0];
    end
  end
endmodule

// File: rtl/pic_intc.sv
module pic_intc
  import pic_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            wr,
  input  logic            rd,
  input  logic            a0,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NLVL-1:0] irq_in,
  input  logic            inta,
  output logic            intr
);
  localparam int LW = $clog2(NLVL);
  localparam int BW = DW - LW;

  logic [NLVL-1:0] irr, isr, imr, eoi_clr, aeoi_clr, ack_set, cand;
  logic            level_mode, auto_eoi, spec_mask, rd_isr, init_clr, seq_ready;
  logic [BW-1:0]   base_hi;
  logic [LW-1:0]   low_lvl;
  logic            req_any, isr_any;
  logic [LW-1:0]   req_idx, req_rank, isr_hi, isr_rank;
  logic            ack_second, ack_spur, first_pulse, grant;
  logic [LW-1:0]   ack_lvl;

  pic_req_latch #(.NLVL(NLVL)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .take(ack_set), .irr(irr)
  );

  assign cand = spec_mask ? (irr & ~imr & ~isr) : (irr & ~imr);

  pic_prio_pick #(.NLVL(NLVL)) u_pick_req (
    .vec(cand), .low_lvl(low_lvl), .any(req_any), .idx(req_idx), .rank(req_rank)
  );

  pic_prio_pick #(.NLVL(NLVL)) u_pick_isr (
    .vec(isr), .low_lvl(low_lvl), .any(isr_any), .idx(isr_hi), .rank(isr_rank)
  );

  pic_cmd_ctrl #(.NLVL(NLVL), .DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cs && wr), .a0(a0), .wdata(wdata),
    .isr_any(isr_any), .isr_hi(isr_hi), .imr(imr), .level_mode(level_mode),
    .base_hi(base_hi), .auto_eoi(auto_eoi), .spec_mask(spec_mask), .rd_isr(rd_isr),
    .low_lvl(low_lvl), .init_clr(init_clr), .eoi_clr(eoi_clr), .seq_ready(seq_ready)
  );

  assign intr = spec_mask ? req_any
                          : (req_any && (!isr_any || (req_rank < isr_rank)));

  assign first_pulse = inta && !ack_second;
  assign grant       = first_pulse && intr;

  always_comb begin
    ack_set  = '0;
    aeoi_clr = '0;
    if (grant) ack_set[req_idx] = 1'b1;
    if (inta && ack_second && auto_eoi && !ack_spur) aeoi_clr[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr        <= '0;
      ack_second <= 1'b0;
      ack_spur   <= 1'b0;
      ack_lvl    <= '0;
    end else begin
      if (init_clr) isr <= '0;
      else          isr <= (isr & ~eoi_clr & ~aeoi_clr) | ack_set;
      if (first_pulse) begin
        ack_lvl  <= grant ? req_idx : LW'(NLVL - 1);
        ack_spur <= !grant;
      end
      if (init_clr)  ack_second <= 1'b0;
      else if (inta) ack_second <= !ack_second;
    end
  end

  always_comb begin
    if (inta)          rdata = ack_second ? {base_hi, ack_lvl} : CALL_OPCODE;
    else if (cs && rd) rdata = a0 ? imr : (rd_isr ? isr : irr);
    else               rdata = '0;
  end
endmodule

// File: rtl/pic_intc_chk.sv
module pic_intc_chk #(
  parameter int NLVL = 8,
  parameter int DW   = 8,
  localparam int LW  = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            wr,
  input logic            a0,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic            inta,
  input logic            intr,
  input logic [NLVL-1:0] irr,
  input logic [NLVL-1:0] isr,
  input logic [NLVL-1:0] imr,
  input logic            ack_second,
  input logic            ack_spur,
  input logic [LW-1:0]   ack_lvl,
  input logic            auto_eoi,
  input logic            seq_ready
);
  AST_ACK_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !ack_second) |-> (rdata == 8'hCD)); // R5
  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && ack_second) |-> (rdata[LW-1:0] == ack_lvl)); // R6
  AST_INTR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ((irr & ~imr) != '0)); // R4
  AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !ack_second && intr && !(cs && wr)) |=> ((isr & ~$past(isr)) != '0)); // R5
  AST_SPUR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !ack_second && !intr && !(cs && wr)) |=> (isr == $past(isr))); // R6
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && a0 && seq_ready) |=> (imr == $past(wdata[NLVL-1:0]))); // R7
  AST_AUTO_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && ack_second && auto_eoi && !ack_spur && !(cs && wr)) |=> !isr[$past(ack_lvl)]); // R10
endmodule

bind pic_intc pic_intc_chk #(.NLVL(NLVL), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .wdata(wdata),
  .rdata(rdata), .inta(inta), .intr(intr), .irr(irr), .isr(isr), .imr(imr),
  .ack_second(ack_second), .ack_spur(ack_spur), .ack_lvl(ack_lvl),
  .auto_eoi(auto_eoi), .seq_ready(seq_ready)
);

// File: tb/tb_pic_intc.sv
module tb_pic_intc;
  logic clk = 0, rst_n = 0;
  logic cs = 0, wr = 0, rd = 0, a0 = 0, inta = 0;
  logic [7:0] wdata = 0, irq = 0;
  logic [7:0] rdata;
  logic intr;
  int checks = 0, errors = 0;
  bit run = 0, done = 0;

  always #10 clk = ~clk;

  pic_intc dut (.clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .a0(a0),
    .wdata(wdata), .rdata(rdata), .irq_in(irq), .inta(inta), .intr(intr));

  // behavioural reference state
  logic [7:0] m_irr, m_isr, m_imr, m_prev, m_base;
  int m_low, m_seq, m_lvl;
  bit m_ltim, m_need4, m_aeoi, m_smm, m_rsel, m_second, m_spur;

  function automatic int prank(int i);
    return (i - m_low - 1 + 16) % 8;
  endfunction

  function automatic int best(logic [7:0] v);
    int b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || prank(i) < prank(b))) b = i;
    return b;
  endfunction

  function automatic logic [7:0] m_cand();
    return m_smm ? (m_irr & ~m_imr & ~m_isr) : (m_irr & ~m_imr);
  endfunction

  function automatic bit m_intr();
    int b = best(m_cand());
    int h = best(m_isr);
    if (b < 0) return 0;
    if (m_smm) return 1;
    return (h < 0) || (prank(b) < prank(h));
  endfunction

  function automatic logic [7:0] exp_rdata();
    if (inta) return m_second ? {m_base[7:3], 3'(m_lvl)} : 8'hCD;
    if (cs && rd) return a0 ? m_imr : (m_rsel ? m_isr : m_irr);
    return 8'h00;
  endfunction

  task automatic model_step();
    logic [7:0] setb = 0, aclr = 0, eclr = 0, nxt;
    bit initc = 0, nsec = m_second, g;
    int h = best(m_isr), L = int'(wdata[2:0]);
    g = m_intr();
    if (inta && !m_second) begin
      if (g) begin setb[best(m_cand())] = 1; m_lvl = best(m_cand()); m_spur = 0; end
      else begin m_lvl = 7; m_spur = 1; end
      nsec = 1;
    end else if (inta && m_second) begin
      nsec = 0;
      if (m_aeoi && !m_spur) aclr[m_lvl] = 1;
    end
    nxt = m_ltim ? irq : ((m_irr | (irq & ~m_prev)) & irq);
    m_irr = nxt & ~setb;
    m_prev = irq;
    if (cs && wr) begin
      if (!a0 && wdata[4]) begin
        initc = 1; m_ltim = wdata[3]; m_need4 = wdata[0]; m_aeoi = 0; m_imr = 0;
        m_low = 7; m_smm = 0; m_rsel = 0; m_seq = 1;
      end else if (a0) begin
        if (m_seq == 1) begin m_base = wdata; m_seq = m_need4 ? 2 : 0; end
        else if (m_seq == 2) begin m_aeoi = wdata[1]; m_seq = 0; end
        else m_imr = wdata;
      end else if (m_seq == 0 && !wdata[3]) begin
        case (wdata[7:5])
          3'b001: if (h >= 0) eclr[h] = 1;
          3'b101: if (h >= 0) begin eclr[h] = 1; m_low = h; end
          3'b011: eclr[L] = 1;
          3'b111: begin eclr[L] = 1; m_low = L; end
          3'b110: m_low = L;
          default: ;
        endcase
      end else if (m_seq == 0) begin
        if (wdata[6]) m_smm = wdata[5];
        if (wdata[1]) m_rsel = wdata[0];
      end
    end
    m_isr = initc ? 8'h00 : ((m_isr & ~eclr & ~aclr) | setb);
    m_second = initc ? 0 : nsec;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0; m_base = 0;
      m_low = 7; m_seq = 0; m_lvl = 0; m_ltim = 0; m_need4 = 0; m_aeoi = 0;
      m_smm = 0; m_rsel = 0; m_second = 0; m_spur = 0;
    end else model_step();
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (run) begin
      #3;
      chk(inta ? (m_second ? "R6" : "R5") : "R12", "rdata model", int'(rdata), int'(exp_rdata()));
      chk("R4", "intr model", int'(intr), int'(m_intr()));
    end
  end

  task automatic wcmd(bit a, logic [7:0] d);
    cs = 1; wr = 1; a0 = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rchk(bit a, logic [7:0] e, string tag);
    cs = 1; rd = 1; a0 = a;
    #2 chk(tag, "read", int'(rdata), int'(e));
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic ack(logic [7:0] e, string tag);
    inta = 1;
    #2 chk(tag, "ack byte", int'(rdata), int'(e));
    @(negedge clk);
    inta = 0;
  endtask

  task automatic ack2(logic [7:0] vec, string tag);
    ack(8'hCD, "R5");
    ack(vec, tag);
  endtask

  task automatic ick(bit e, string tag);
    #1 chk(tag, "intr", int'(intr), int'(e));
  endtask

  task automatic setirq(logic [7:0] v);
    irq = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    // R1 reset state
    ick(0, "R1");
    rchk(1, 8'hFF, "R1");
    rchk(0, 8'h00, "R1");
    // R3 initialization, edge mode, base 0x40
    wcmd(0, 8'h10);
    wcmd(1, 8'h40);
    wcmd(1, 8'h00);
    rchk(1, 8'h00, "R3");
    // R4 nesting and R5/R6 vectoring
    setirq(8'h08);
    ick(1, "R4");
    rchk(0, 8'h08, "R12");
    ack2(8'h43, "R6");
    wcmd(0, 8'h0B);
    rchk(0, 8'h08, "R12");
    setirq(8'h28);
    ick(0, "R4");
    setirq(8'h2A);
    ick(1, "R4");
    ack2(8'h41, "R6");
    wcmd(0, 8'h20);
    rchk(0, 8'h08, "R8");
    ick(0, "R8");
    wcmd(0, 8'h63);
    ick(1, "R8");
    ack2(8'h45, "R8");
    wcmd(0, 8'h20);
    setirq(8'h00);
    // R2 edge request dropped before acknowledge
    setirq(8'h40);
    ick(1, "R2");
    setirq(8'h00);
    ick(0, "R2");
    wcmd(0, 8'h0A);
    rchk(0, 8'h00, "R2");
    // R7 masking
    wcmd(1, 8'h04);
    setirq(8'h04);
    ick(0, "R7");
    rchk(0, 8'h04, "R7");
    wcmd(1, 8'h00);
    ick(1, "R7");
    ack2(8'h42, "R7");
    wcmd(0, 8'h20);
    setirq(8'h00);
    // R9 rotation
    wcmd(0, 8'hC4);
    setirq(8'h41);
    ick(1, "R9");
    ack2(8'h46, "R9");
    wcmd(0, 8'hA0);
    ick(1, "R9");
    ack2(8'h40, "R9");
    wcmd(0, 8'hE0);
    setirq(8'h00);
    setirq(8'h81);
    ack2(8'h47, "R9");
    wcmd(0, 8'h0B);
    rchk(0, 8'h80, "R9");
    wcmd(0, 8'h67);
    ick(1, "R9");
    ack2(8'h40, "R9");
    wcmd(0, 8'h60);
    wcmd(0, 8'hC7);
    setirq(8'h00);
    // R6 acknowledge with nothing pending
    ick(0, "R6");
    ack2(8'h47, "R6");
    rchk(0, 8'h00, "R6");
    // R11 special mask mode
    setirq(8'h08);
    ack2(8'h43, "R6");
    wcmd(1, 8'h08);
    setirq(8'h28);
    ick(0, "R11");
    wcmd(0, 8'h68);
    ick(1, "R11");
    ack2(8'h45, "R11");
    rchk(0, 8'h28, "R11");
    wcmd(0, 8'h48);
    ick(0, "R11");
    wcmd(0, 8'h63);
    wcmd(0, 8'h65);
    wcmd(1, 8'h00);
    setirq(8'h00);
    // R13 end-of-interrupt write in the cycle of the first acknowledge pulse
    setirq(8'h10);
    ack2(8'h44, "R6");
    setirq(8'h14);
    ick(1, "R13");
    cs = 1; wr = 1; a0 = 0; wdata = 8'h20; inta = 1;
    #2 chk("R13", "ack byte with write", int'(rdata), 8'hCD);
    @(negedge clk);
    cs = 0; wr = 0; inta = 0;
    ack(8'h42, "R13");
    rchk(0, 8'h04, "R13");
    wcmd(0, 8'h20);
    setirq(8'h00);
    // R10 automatic end-of-interrupt, level mode, mode word present
    wcmd(0, 8'h19);
    wcmd(1, 8'h80);
    wcmd(1, 8'h02);
    rchk(1, 8'h00, "R3");
    setirq(8'h04);
    ick(1, "R2");
    ack2(8'h82, "R10");
    wcmd(0, 8'h0B);
    rchk(0, 8'h00, "R10");
    ick(1, "R2");
    setirq(8'h00);
    ick(0, "R2");
    wcmd(0, 8'h0A);
    rchk(0, 8'h00, "R2");
    run = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule